// File: doc/BRIEF.md
# Inter-processor sample handoff controller

This controller moves one audio frame at a time between a packed PCM port and a processing engine, using a small shared buffer. When a 32-bit PCM input word arrives, the controller splits it into two 16-bit samples and stores them in a four-entry input buffer. The primary channel sits in the upper half of the word and the reference channel in the lower half. The controller then enables the engine and issues a one-cycle processing request.

After the request, the controller watches a status line driven by the engine. The line is 1 while the engine is halted and 0 while it works. A drop to 0 followed by a return to 1 marks completion. On completion, the controller captures the engine result. The value it files into a cyclic four-entry output buffer, and then presents on the 32-bit PCM output register, is the result of the previous request. This gives a fixed latency of one sample.

The engine enable is held low whenever the controller is idle. Both buffers remain readable through a byte-addressed read port at all times, including while the engine is gated. A PCM word that arrives while a request is in flight is dropped, and a sticky flag records the overrun.

Top module: `sample_handoff`

## Requirements
- R1: After reset, eng_en, eng_req, pcm_out_valid and overrun are 0 and pcm_out_word is 0.
- R2: An accepted word stores bits [31:16] at input entry p and bits [15:0] at entry p+1 (mod 4). p starts at 0 and advances by 2 per accepted word. Input entry i is read at byte address 2*i.
- R3: In the cycle after a word is accepted, eng_req is high for exactly one cycle, with eng_en high.
- R4: eng_en is low whenever the controller is idle, including the cycle in which pcm_out_valid is high. It is high from the request until the output is presented. The read port returns buffer contents while eng_en is low.
- R5: Completion requires eng_status to be seen at 0 and then at 1 after the request. A status held at 1 never completes.
- R6: Two cycles after the status returns to 1, pcm_out_valid pulses for one cycle. At the same time, pcm_out_word carries the previous request's result in bits [15:0] and zero in bits [31:16]; for the first request the result field is 0.
- R7: The output pointer starts at 0 and advances by one (mod 4) per request, before that request's result is filed. Request k files the previous result at output entry k mod 4, read at byte address 16 + 2*(k mod 4).
- R8: A word with pcm_in_valid high while the controller is not idle is dropped, leaving the input buffer unchanged. It sets overrun, which stays 1 until reset.
- R9: pcm_out_word holds its value in every cycle in which pcm_out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pcm_in_valid | input | 1 | PCM input register occupied (one-cycle strobe) |
| pcm_in_word | input | 32 | Packed input: primary [31:16], reference [15:0] |
| eng_en | output | 1 | Engine clock enable |
| eng_req | output | 1 | Processing request, sets the engine action flag |
| eng_status | input | 1 | Engine status: 0 busy, 1 halted |
| eng_result | input | 16 | Sample computed by the engine |
| buf_addr | input | 5 | Byte address into the shared buffer (bit 4 selects the output region) |
| buf_rd_data | output | 16 | Buffer entry at buf_addr |
| pcm_out_word | output | 32 | PCM output register |
| pcm_out_valid | output | 1 | Output register updated (one-cycle pulse) |
| overrun | output | 1 | Sticky dropped-word flag |

## Verification
The bench holds the status line at 1 for several cycles after a request before dropping it. A controller that treated a steady 1 as completion would present output early. It probes overrun by sending a word mid-request and then reading back all input entries: a design that accepted the word would show corrupted entries and an out-of-step pair pointer. Every presented word and every output-buffer entry is compared with the previous result, so a design without the one-sample lag, or with a pointer that advances at the wrong moment, mismatches on the first frame or on the fifth, where the pointer wraps. Buffer reads are made while eng_en is low, so any coupling between the read path and the engine enable shows up there.

// File: rtl/sample_handoff.sv
module sample_handoff #(
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pcm_in_valid,
  input  logic [2*DW-1:0] pcm_in_word,
  output logic            eng_en,
  output logic            eng_req,
  input  logic            eng_status,
  input  logic [DW-1:0]   eng_result,
  input  logic [4:0]      buf_addr,
  output logic [DW-1:0]   buf_rd_data,
  output logic [2*DW-1:0] pcm_out_word,
  output logic            pcm_out_valid,
  output logic            overrun
);
  localparam int PW = 2 * DW;
  localparam int IW = $clog2(DEPTH);
  localparam int AW = 5;

  typedef enum logic [1:0] {IDLE, WORK, WAIT, DONE} st_t;

  st_t           state;
  logic [DW-1:0] in_buf  [DEPTH];
  logic [DW-1:0] out_buf [DEPTH];
  logic [IW-1:0] in_ptr, out_ptr;
  logic [DW-1:0] held;
  logic          busy_seen;

  wire [IW-1:0] rd_idx = buf_addr[IW:1];
  wire          unused_addr_bits = ^{buf_addr[0], buf_addr[AW-2:IW+1]};
  wire          finish = (state == WAIT) && busy_seen && eng_status;

  assign eng_en      = (state != IDLE);
  assign eng_req     = (state == WORK);
  assign buf_rd_data = buf_addr[AW-1] ? out_buf[rd_idx] : in_buf[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= IDLE;
      in_ptr        <= '0;
      out_ptr       <= '0;
      held          <= '0;
      busy_seen     <= 1'b0;
      pcm_out_word  <= '0;
      pcm_out_valid <= 1'b0;
      overrun       <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        in_buf[i]  <= '0;
        out_buf[i] <= '0;
      end
    end else begin
      pcm_out_valid <= 1'b0;
      if (pcm_in_valid && state != IDLE) overrun <= 1'b1;
      case (state)
        IDLE: if (pcm_in_valid) begin
          in_buf[in_ptr]          <= pcm_in_word[PW-1:DW];
          in_buf[in_ptr + IW'(1)] <= pcm_in_word[DW-1:0];
          in_ptr                  <= in_ptr + IW'(2);
          state                   <= WORK;
        end
        WORK: begin
          out_ptr   <= out_ptr + IW'(1);
          busy_seen <= 1'b0;
          state     <= WAIT;
        end
        WAIT: begin
          if (!eng_status) busy_seen <= 1'b1;
          if (finish) begin
            out_buf[out_ptr] <= held;
            held             <= eng_result;
            state            <= DONE;
          end
        end
        DONE: begin
          pcm_out_word  <= {{(PW-DW){1'b0}}, out_buf[out_ptr]};
          pcm_out_valid <= 1'b1;
          state         <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sample_handoff_chk.sv
module sample_handoff_chk #(
  parameter int PW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eng_en,
  input logic          eng_req,
  input logic [PW-1:0] pcm_out_word,
  input logic          pcm_out_valid,
  input logic          overrun
);
  assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |=> !eng_req);

  assert_req_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |-> eng_en);

  assert_gated_on_output_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_out_valid |-> !eng_en);

  assert_out_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_out_valid |=> !pcm_out_valid);

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pcm_out_valid |-> $stable(pcm_out_word));
endmodule

bind sample_handoff sample_handoff_chk #(.PW(2*DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .eng_en(eng_en), .eng_req(eng_req),
  .pcm_out_word(pcm_out_word), .pcm_out_valid(pcm_out_valid), .overrun(overrun)
);

// File: tb/sample_handoff_test.sv
module sample_handoff_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        pcm_in_valid = 0;
  logic [31:0] pcm_in_word = 0;
  logic        eng_en, eng_req, pcm_out_valid, overrun;
  logic        eng_status = 1;
  logic [15:0] eng_result = 0;
  logic [4:0]  buf_addr = 0;
  logic [15:0] buf_rd_data;
  logic [31:0] pcm_out_word;

  sample_handoff uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [15:0] m_in [4];
  logic [15:0] m_out [4];
  int m_inp = 0, m_outp = 0;
  logic [15:0] m_prev = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [15:0] r);
    return {16'h0000, r};
  endfunction

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    buf_addr = a;
    #1;
    d = buf_rd_data;
  endtask

  task automatic check_inputs();
    logic [15:0] d;
    for (int i = 0; i < 4; i++) begin
      rd(5'(2*i), d);
      chk(d == m_in[i], "R2 input entry", {16'h0, d}, {16'h0, m_in[i]});
    end
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    pcm_in_valid = 1; pcm_in_word = w;
    @(negedge clk);
    pcm_in_valid = 0;
    m_in[m_inp] = w[31:16];
    m_in[(m_inp+1)%4] = w[15:0];
    m_inp = (m_inp + 2) % 4;
  endtask

  task automatic serve(input logic [15:0] res, input int pre, input int busy, input bit probe);
    logic [15:0] d;
    logic [31:0] last;
    last = pcm_out_word;
    chk(eng_req && eng_en, "R3 request with enable", {30'h0, eng_en, eng_req}, 32'h3);
    m_outp = (m_outp + 1) % 4;
    @(negedge clk);
    chk(!eng_req, "R3 single-cycle request", {31'h0, eng_req}, 32'h0);
    for (int i = 0; i < pre; i++) begin
      @(negedge clk);
      chk(!pcm_out_valid && eng_en, "R5 no completion on steady 1", {30'h0, eng_en, pcm_out_valid}, 32'h2);
      chk(pcm_out_word == last, "R9 output holds", pcm_out_word, last);
    end
    if (probe) begin
      pcm_in_valid = 1; pcm_in_word = $urandom;
      @(negedge clk);
      pcm_in_valid = 0;
      chk(overrun, "R8 overrun set", {31'h0, overrun}, 32'h1);
    end
    eng_status = 0;
    for (int i = 0; i < busy; i++) @(negedge clk);
    eng_result = res; eng_status = 1;
    @(negedge clk);
    chk(!pcm_out_valid, "R6 latency (early)", {31'h0, pcm_out_valid}, 32'h0);
    @(negedge clk);
    chk(pcm_out_valid, "R6 output pulse", {31'h0, pcm_out_valid}, 32'h1);
    chk(pcm_out_word == exp_word(m_prev), "R6 previous result", pcm_out_word, exp_word(m_prev));
    chk(!eng_en, "R4 gated when idle", {31'h0, eng_en}, 32'h0);
    m_out[m_outp] = m_prev;
    m_prev = res;
    rd(5'(16 + 2*m_outp), d);
    chk(d == m_out[m_outp], "R7 output entry", {16'h0, d}, {16'h0, m_out[m_outp]});
    check_inputs();
  endtask

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < 4; i++) begin m_in[i] = 0; m_out[i] = 0; end
    repeat (3) @(negedge clk);
    chk(!eng_en && !eng_req && !pcm_out_valid && !overrun && pcm_out_word == 0,
        "R1 reset state", {eng_en, eng_req, pcm_out_valid, overrun, pcm_out_word[27:0]}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk(!eng_en, "R4 gated after reset", {31'h0, eng_en}, 32'h0);
    check_inputs();

    push(32'hA1B2_C3D4);
    chk(eng_en, "R4 enabled during request", {31'h0, eng_en}, 32'h1);
    serve(16'h1111, 4, 2, 0);
    chk(!overrun, "R8 no overrun yet", {31'h0, overrun}, 32'h0);
    repeat (5) @(negedge clk);
    chk(pcm_out_word == exp_word(16'h0000) && !eng_en, "R9 hold while idle", pcm_out_word, 32'h0);

    push(32'hFFFF_0001);
    serve(16'h8000, 1, 1, 1);

    for (int n = 0; n < 40; n++) begin
      logic [31:0] w;
      logic [15:0] r;
      w = $urandom;
      r = 16'($urandom);
      push(w);
      serve(r, int'($urandom % 4), 1 + int'($urandom % 5), ($urandom % 8) == 0);
      repeat (int'($urandom % 3)) @(negedge clk);
    end
    chk(overrun, "R8 overrun sticky", {31'h0, overrun}, 32'h1);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule